// File: doc/BRIEF.md
# Register-Addressed I2C Target

This block is an I2C target with a fixed 7-bit device address placed in front of a small array of byte registers, much like a serial memory. A write transaction first loads an internal register pointer and then stores each following data byte at the pointed location. After each stored byte the pointer steps to the next location.

A read transaction returns bytes starting at the current pointer and steps the pointer after every byte. The master usually enters a read through a repeated START after it has written the pointer. It can also enter one directly to continue from where the last access ended.

SCL and SDA are inputs that pass through two-flop synchronizers into a system clock at least eight times faster than SCL. SDA is driven only through an open-drain enable. The block does not stretch the clock.

Top module: `i2c_reg_target`

## Requirements
- R1: After a START, the target shifts in eight bits MSB first. Bits 7..1 are the device address (default 7'h42) and bit 0 is the direction: 0 means the target receives and 1 means it transmits.
- R2: For a matching address, and for every byte it receives afterwards, the target pulls SDA low (sdaOe=1) through the ninth SCL pulse. It releases SDA after that pulse's falling edge.
- R3: On an address mismatch, the target leaves SDA released on the ninth clock and on every clock that follows. Bytes sent before the next START do not change any register.
- R4: In a write, the byte after the address sets the pointer to its value modulo 16. Later data bytes go to the pointer, pointer+1 and so on, and location 15 is followed by location 0.
- R5: In a read, the target sends the register at the pointer MSB first. It then increments the pointer with the same wrap from 15 to 0.
- R6: When the master ACKs (SDA low on the ninth clock), the target drives the next byte. When the master NACKs, the target releases SDA and keeps it released until the next START or STOP.
- R7: The target changes its SDA drive only while SCL is low.
- R8: The target detects START (SDA falling while SCL is high) and STOP (SDA rising while SCL is high) in every state, including in the middle of a byte. STOP returns it to idle. START restarts address matching without changing the pointer.
- R9: The pointer keeps its value across transactions, so a read that sends no pointer continues from where the previous access ended.
- R10: After reset, SDA is released, all 16 registers read as 0x00 and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Sampled serial clock line |
| sdaIn | input | 1 | Sampled serial data line |
| sdaOe | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
The embedded properties check several rules on every cycle. SDA drive changes only while the synchronized SCL is low. STOP always leaves SDA released and the controller idle, and START always restarts address collection. The bit counter never runs past the acknowledge slot. Each write or transmit load steps the pointer with wrap-around and presents the addressed register. The bench scenarios cover the rest, checking against a reference register model: address rejection with later writes ignored, pointer wrap, pointer retention across transactions, master NACK ending a read, and START or STOP arriving mid-byte.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_SACK,
    ST_RDATA,
    ST_MACK
  } tgtState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftRx;  // shift in sampled SDA
    logic setPtr;   // pointer <= received byte
    logic wrMem;    // store received byte, step pointer
    logic loadTx;   // load register at pointer, step pointer
    logic shiftTx;  // present next transmit bit
  } dpStrobe_t;

endpackage

// File: rtl/i2c_tgt_dp.sv
module i2c_tgt_dp
  import i2c_tgt_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  parameter int SYNC  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  dpStrobe_t  stb,
  output logic       sclSync,
  output logic       sdaSync,
  output logic       sclRise,
  output logic       sclFall,
  output logic       startDet,
  output logic       stopDet,
  output logic [WIDTH-1:0] rxByte,
  output logic       txBit
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [1:0] pinVec, curLvl, prvLvl;
  assign pinVec = {sclIn, sdaIn};

  for (genvar g = 0; g < 2; g++) begin : gSync
    logic [SYNC:0] q;
    always_ff @(posedge clk) begin
      if (!rstN) q <= '1;
      else       q <= {q[SYNC-1:0], pinVec[g]};
    end
    assign curLvl[g] = q[SYNC-1];
    assign prvLvl[g] = q[SYNC];
  end

  assign sclSync  = curLvl[1];
  assign sdaSync  = curLvl[0];
  assign sclRise  =  curLvl[1] & ~prvLvl[1];
  assign sclFall  = ~curLvl[1] &  prvLvl[1];
  assign startDet =  curLvl[1] &  prvLvl[1] &  prvLvl[0] & ~curLvl[0];
  assign stopDet  =  curLvl[1] &  prvLvl[1] & ~prvLvl[0] &  curLvl[0];

  logic [WIDTH-1:0] shReg;
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    ptr;
  logic [WIDTH-1:0] memAtPtr;

  function automatic logic [PW-1:0] stepPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign memAtPtr = mem[ptr];
  assign rxByte   = shReg;
  assign txBit    = shReg[WIDTH-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg <= '1;
      ptr   <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (stb.shiftRx) shReg <= {shReg[WIDTH-2:0], sdaSync};
      if (stb.shiftTx) shReg <= {shReg[WIDTH-2:0], 1'b1};
      if (stb.setPtr)  ptr   <= PW'(32'(shReg) % DEPTH);
      if (stb.wrMem) begin
        mem[ptr] <= shReg;
        ptr      <= stepPtr(ptr);
      end
      if (stb.loadTx) begin
        shReg <= memAtPtr;
        ptr   <= stepPtr(ptr);
      end
    end
  end

  // R4: a stored byte lands at the old pointer and the pointer steps with wrap
  p_wr_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrMem |=> (ptr == stepPtr($past(ptr))) && (mem[$past(ptr)] == $past(shReg)));

  // R5: a transmit load presents the addressed register and steps the pointer
  p_tx_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadTx |=> (shReg == $past(memAtPtr)) && (ptr == stepPtr($past(ptr))));

endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter int         WIDTH    = 8,
  parameter logic [6:0] DEV_ADDR = 7'h42
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclSync,
  input  logic       sdaSync,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic [WIDTH-1:0] rxByte,
  input  logic       txBit,
  output dpStrobe_t  stb,
  output logic       sdaOe
);

  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] FULL = CW'(WIDTH);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  tgtState_t state, stateN, retState, retN;
  logic [CW-1:0] bitCnt, cntN;
  logic mAck, mAckN;

  always_comb begin
    stateN = state;
    retN   = retState;
    cntN   = bitCnt;
    mAckN  = mAck;
    stb    = '0;
    if (startDet) begin
      stateN = ST_ADDR;
      cntN   = '0;
    end else if (stopDet) begin
      stateN = ST_IDLE;
    end else begin
      case (state)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (sclRise && bitCnt < FULL) begin
            stb.shiftRx = 1'b1;
            cntN        = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == FULL) begin
            stateN = ST_SACK;
            if (state == ST_ADDR) begin
              if (rxByte[WIDTH-1:WIDTH-7] != DEV_ADDR) stateN = ST_IDLE;
              retN = rxByte[0] ? ST_RDATA : ST_PTR;
            end else if (state == ST_PTR) begin
              stb.setPtr = 1'b1;
              retN       = ST_WDATA;
            end else begin
              stb.wrMem = 1'b1;
              retN      = ST_WDATA;
            end
          end
        end
        ST_SACK: if (sclFall) begin
          stateN = retState;
          cntN   = '0;
          if (retState == ST_RDATA) stb.loadTx = 1'b1;
        end
        ST_RDATA: if (sclFall) begin
          if (bitCnt == LAST) stateN = ST_MACK;
          else begin
            stb.shiftTx = 1'b1;
            cntN        = bitCnt + 1'b1;
          end
        end
        ST_MACK: begin
          if (sclRise) mAckN = !sdaSync;
          else if (sclFall) begin
            if (mAck) begin
              stateN     = ST_RDATA;
              cntN       = '0;
              stb.loadTx = 1'b1;
            end else begin
              stateN = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      retState <= ST_IDLE;
      bitCnt   <= '0;
      mAck     <= 1'b0;
    end else begin
      state    <= stateN;
      retState <= retN;
      bitCnt   <= cntN;
      mAck     <= mAckN;
    end
  end

  assign sdaOe = (state == ST_SACK) || (state == ST_RDATA && !txBit);

  // R7: drive changes only while SCL is low (bus conditions excepted)
  p_sda_scl_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> (!sclSync || $past(startDet || stopDet)));

  // R8: STOP leaves the target idle and released
  p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stopDet && !startDet) |=> (state == ST_IDLE) && !sdaOe);

  // R8: START restarts address collection from bit zero
  p_start_addr_r8: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == ST_ADDR) && (bitCnt == '0) && !sdaOe);

  // R1: never more than one byte collected before the acknowledge slot
  p_bitcnt_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= FULL);

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter int         WIDTH    = 8,
  parameter int         DEPTH    = 16,
  parameter int         SYNC     = 2,
  parameter logic [6:0] DEV_ADDR = 7'h42
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe
);

  dpStrobe_t        stb;
  logic             sclSync, sdaSync, sclRise, sclFall, startDet, stopDet, txBit;
  logic [WIDTH-1:0] rxByte;

  i2c_tgt_dp #(.WIDTH(WIDTH), .DEPTH(DEPTH), .SYNC(SYNC)) uDp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .stb(stb),
    .sclSync(sclSync), .sdaSync(sdaSync), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .rxByte(rxByte), .txBit(txBit)
  );

  i2c_tgt_ctrl #(.WIDTH(WIDTH), .DEV_ADDR(DEV_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .sclSync(sclSync), .sdaSync(sdaSync),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .rxByte(rxByte), .txBit(txBit), .stb(stb), .sdaOe(sdaOe)
  );

endmodule

// File: tb/i2c_reg_target_test.sv
`timescale 1ns/1ps
module i2c_reg_target_test;

  localparam int Q = 10;
  localparam logic [6:0] DEV = 7'h42;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaOe;
  logic sdaLine;

  always #2.5 clk = ~clk;
  assign sdaLine = sdaM & ~sdaOe;

  i2c_reg_target uut (.clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe));

  int checks = 0;
  int errors = 0;
  int r7Viol = 0;
  int driveSeen = 0;
  logic prevOe = 1'b0;
  logic [7:0] model [16];
  int mPtr = 0;

  always @(negedge clk) begin
    if (rstN && sdaOe !== prevOe && sclM) r7Viol++;
    if (sdaOe) driveSeen++;
    prevOe <= sdaOe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ(input int n = Q);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart;
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic busStop;
    sdaM = 1'b0; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b1; waitQ();
  endtask

  task automatic putBit(input logic b);
    sdaM = b; waitQ();
    sclM = 1'b1; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic getBit(output logic b);
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ(Q / 2);
    b = sdaLine; waitQ(Q - Q / 2);
    sclM = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] d, output logic ackLvl);
    for (int i = 7; i >= 0; i--) putBit(d[i]);
    getBit(ackLvl);
  endtask

  task automatic recvByte(input logic giveAck, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      getBit(b);
      d[i] = b;
    end
    putBit(giveAck ? 1'b0 : 1'b1);
  endtask

  task automatic doWrite(input logic [7:0] p, input int len, input string tag);
    logic a;
    logic [7:0] d;
    busStart();
    sendByte({DEV, 1'b0}, a); chk({tag, " R1 addr ack"}, a, 0);
    sendByte(p, a);           chk({tag, " R2 ptr ack"}, a, 0);
    chk({tag, " R2 release after ack"}, sdaOe, 0);
    mPtr = p % 16;
    for (int k = 0; k < len; k++) begin
      d = 8'($urandom);
      sendByte(d, a); chk({tag, " R4 data ack"}, a, 0);
      model[mPtr] = d;
      mPtr = (mPtr + 1) % 16;
    end
    busStop();
  endtask

  task automatic doRead(input int len, input string tag);
    logic [7:0] d;
    for (int k = 0; k < len; k++) begin
      recvByte(k != len - 1, d);
      chk({tag, " R5 read data"}, d, model[mPtr]);
      mPtr = (mPtr + 1) % 16;
    end
    chk({tag, " R6 released after nack"}, sdaOe, 0);
    waitQ(3 * Q);
    chk({tag, " R6 stays released"}, sdaOe, 0);
    busStop();
  endtask

  task automatic readWithPtr(input logic [7:0] p, input int len, input string tag);
    logic a;
    busStart();
    sendByte({DEV, 1'b0}, a); chk({tag, " R1 addr ack"}, a, 0);
    sendByte(p, a);           chk({tag, " R4 ptr ack"}, a, 0);
    mPtr = p % 16;
    busStart();
    sendByte({DEV, 1'b1}, a); chk({tag, " R1 read addr ack"}, a, 0);
    doRead(len, tag);
  endtask

  task automatic readCont(input int len, input string tag);
    logic a;
    busStart();
    sendByte({DEV, 1'b1}, a); chk({tag, " R9 addr ack"}, a, 0);
    doRead(len, tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    waitQ(5);
    rstN = 1'b1;
    waitQ(5);

    // R10: reset state
    chk("R10 sdaOe after reset", sdaOe, 0);
    readCont(2, "reset");

    // R4/R5: wrap from 15 to 0 on write and read
    doWrite(8'd14, 4, "wrap");
    readWithPtr(8'h3E, 4, "wrap");

    // R3: mismatched address and its data are ignored
    busStart();
    driveSeen = 0;
    sendByte({7'h13, 1'b0}, a); chk("R3 mismatch no ack", a, 1);
    sendByte(8'h05, a);         chk("R3 ptr byte ignored", a, 1);
    sendByte(8'hA5, a);         chk("R3 data byte ignored", a, 1);
    chk("R3 never drove", driveSeen, 0);
    busStop();
    readWithPtr(8'h05, 1, "mismatch");

    // R8: START in the middle of a pointer byte keeps the pointer
    busStart();
    sendByte({DEV, 1'b0}, a); chk("R8 addr ack", a, 0);
    putBit(1'b1); putBit(1'b0); putBit(1'b1);
    busStart();
    sendByte({DEV, 1'b1}, a); chk("R8 restart read ack", a, 0);
    doRead(1, "midbyte");

    // R8: STOP inside an address byte, then normal service
    busStart();
    putBit(1'b1); putBit(1'b0); putBit(1'b0);
    busStop();
    chk("R8 idle after stop", sdaOe, 0);
    readCont(2, "afterstop");

    // random mix of writes, pointed reads and continued reads (R9)
    for (int it = 0; it < 24; it++) begin
      int op;
      int len;
      op  = int'($urandom % 3);
      len = 1 + int'($urandom % 4);
      d   = 8'($urandom);
      case (op)
        0: doWrite(d, len, "rand");
        1: readWithPtr(d, len, "rand");
        default: readCont(len, "rand");
      endcase
    end

    chk("R7 drive changed with SCL high", r7Viol, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule